// File: doc/BRIEF.md
# Dual-Clock Mailbox Bridge

Two 36-bit bypass registers carry single control words between two ports that run on unrelated clocks. These words do not pass through the data queue. The forward mailbox is written from port A and read at port B. The reverse mailbox is written from port B and read at port A.

Each mailbox has an active-low full flag, and each flag is presented in both clock domains. The writer's copy drops on the edge that accepts a write, and it blocks any further write until the reader has taken the word. The reader's copy drops once the write has crossed the synchronizer, and it rises on the edge that takes the word.

Port A picks the mailbox with a single select bit. Port B picks it by driving the all-ones code on its two-bit bus-size field. The block also steers each port's data output between the queue output and the incoming mailbox, with no byte reordering.

Top module: `mailbox_bridge`

## Requirements
- R1: While rst_ni is low, and after it is released with no traffic, all four flag outputs are 1 and both mailboxes hold zero.
- R2: On a rising clk_a_i edge with a_sel_i, a_wr_i, a_en_i and a_mbx_i all 1 and ab_full_wr_no at 1, the forward mailbox loads a_data_i. No other port A input combination changes the forward mailbox.
- R3: On a rising clk_b_i edge with b_sel_i, b_wr_i and b_en_i all 1, b_size_i equal to 2'b11, and ba_full_wr_no at 1, the reverse mailbox loads b_data_i. Any other port B combination leaves the reverse mailbox unchanged.
- R4: An accepted write drives the writer's flag (ab_full_wr_no or ba_full_wr_no) to 0 after that same edge. The reader's flag (ab_full_rd_no or ba_full_rd_no) falls only after at least two reader-clock edges, and it falls within four of them.
- R5: While the writer's flag is 0, writes to that mailbox are ignored and its content is unchanged.
- R6: A port B read (b_sel_i=1, b_wr_i=0, b_en_i=1, b_size_i=2'b11) of a full forward mailbox sets ab_full_rd_no to 1 after that edge. ab_full_wr_no follows within a few clk_a_i cycles, but not before two clk_a_i edges. A port A read (a_sel_i=1, a_wr_i=0, a_en_i=1, a_mbx_i=1) does the same for the reverse mailbox.
- R7: Mailbox content is unchanged by reads. It remains visible at the output until a new write is accepted.
- R8: a_data_o equals the reverse mailbox when a_mbx_i is 1 and equals a_fifo_i when a_mbx_i is 0.
- R9: b_data_o equals the forward mailbox when b_size_i is 2'b11. For codes 2'b00, 2'b01 and 2'b10 it equals a_fifo_i's counterpart b_fifo_i, bit for bit, with no byte reordering.
- R10: A read of an empty mailbox, and any access that is not qualified, leaves both flags of both mailboxes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_sel_i | input | 1 | Port A chip select, active high |
| a_wr_i | input | 1 | Port A direction, 1 write, 0 read |
| a_en_i | input | 1 | Port A transfer enable |
| a_mbx_i | input | 1 | Port A mailbox select |
| a_data_i | input | 36 | Port A write data |
| a_fifo_i | input | 36 | Queue output presented to port A |
| a_data_o | output | 36 | Port A read data |
| b_sel_i | input | 1 | Port B chip select, active high |
| b_wr_i | input | 1 | Port B direction, 1 write, 0 read |
| b_en_i | input | 1 | Port B transfer enable |
| b_size_i | input | 2 | Port B bus-size code, 2'b11 selects mailbox |
| b_data_i | input | 36 | Port B write data |
| b_fifo_i | input | 36 | Queue output presented to port B |
| b_data_o | output | 36 | Port B read data |
| ab_full_wr_no | output | 1 | Forward mailbox full, clk_a_i domain, active low |
| ab_full_rd_no | output | 1 | Forward mailbox full, clk_b_i domain, active low |
| ba_full_wr_no | output | 1 | Reverse mailbox full, clk_b_i domain, active low |
| ba_full_rd_no | output | 1 | Reverse mailbox full, clk_a_i domain, active low |

## Verification
The bench builds the block with its defaults: a 36-bit word, a two-bit size field with mailbox code 2'b11, and two synchronizer stages. With only four port A control bits and five port B control bits, every control combination on each port can be swept, each with a fresh data word. An arithmetic model is updated after every sweep step, and both flags of both mailboxes are compared against it. The two clocks run at 20 ns and 34 ns periods, and their rising edges never coincide. This makes the bound on the synchronizer latency observable right after each write and read edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef struct packed {
    logic sel;
    logic wr;
    logic en;
    logic mbx;
  } port_req_t;

  localparam int unsigned N_CHAN = 2;
  localparam int unsigned CH_AB  = 0;
  localparam int unsigned CH_BA  = 1;
endpackage

// File: rtl/mbx_req_dec.sv
module mbx_req_dec
  import mbx_pkg::*;
(
  input  port_req_t req_i,
  output logic      wr_o,
  output logic      rd_o
);
  logic hit;
  assign hit  = req_i.sel & req_i.en & req_i.mbx;
  assign wr_o = hit &  req_i.wr;
  assign rd_o = hit & ~req_i.wr;
endmodule

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_req_i,
  output logic [DATA_W-1:0] mail_o,
  output logic              full_w_no,
  output logic              full_r_no
);
  logic [DATA_W-1:0] mail_q;
  logic wr_tgl_q, rd_tgl_q;
  logic wr_tgl_s, rd_tgl_s;
  logic full_w, full_r;
  logic wr_ok, rd_ok;

  // toggles differ while a word is outstanding
  assign full_w = wr_tgl_q ^ rd_tgl_s;
  assign full_r = wr_tgl_s ^ rd_tgl_q;
  assign wr_ok  = wr_req_i & ~full_w;
  assign rd_ok  = rd_req_i &  full_r;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mail_q   <= '0;
      wr_tgl_q <= 1'b0;
    end else if (wr_ok) begin
      mail_q   <= wdata_i;
      wr_tgl_q <= ~wr_tgl_q;
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_tgl_q <= 1'b0;
    else if (rd_ok) rd_tgl_q <= ~rd_tgl_q;
  end

  mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wr_tgl_q),
    .q_o   (wr_tgl_s)
  );

  mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (rd_tgl_q),
    .q_o   (rd_tgl_s)
  );

  assign mail_o    = mail_q;
  assign full_w_no = ~full_w;
  assign full_r_no = ~full_r;
endmodule

// File: rtl/mailbox_bridge.sv
module mailbox_bridge
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SIZE_W      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [SIZE_W-1:0] MAIL_CODE = '1
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              rst_ni,
  input  logic              a_sel_i,
  input  logic              a_wr_i,
  input  logic              a_en_i,
  input  logic              a_mbx_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic [DATA_W-1:0] a_fifo_i,
  output logic [DATA_W-1:0] a_data_o,
  input  logic              b_sel_i,
  input  logic              b_wr_i,
  input  logic              b_en_i,
  input  logic [SIZE_W-1:0] b_size_i,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic [DATA_W-1:0] b_fifo_i,
  output logic [DATA_W-1:0] b_data_o,
  output logic              ab_full_wr_no,
  output logic              ab_full_rd_no,
  output logic              ba_full_wr_no,
  output logic              ba_full_rd_no
);
  port_req_t a_req, b_req;
  logic      b_mbx;
  logic      a_wr, a_rd, b_wr, b_rd;

  assign b_mbx = (b_size_i == MAIL_CODE);
  assign a_req = '{sel: a_sel_i, wr: a_wr_i, en: a_en_i, mbx: a_mbx_i};
  assign b_req = '{sel: b_sel_i, wr: b_wr_i, en: b_en_i, mbx: b_mbx};

  mbx_req_dec u_dec_a (.req_i(a_req), .wr_o(a_wr), .rd_o(a_rd));
  mbx_req_dec u_dec_b (.req_i(b_req), .wr_o(b_wr), .rd_o(b_rd));

  // channel 0: A writes, B reads; channel 1: B writes, A reads
  logic [N_CHAN-1:0] wclk, rclk, wreq, rreq, fw_n, fr_n;
  logic [DATA_W-1:0] wdat [N_CHAN];
  logic [DATA_W-1:0] mail [N_CHAN];

  assign wclk = {clk_b_i, clk_a_i};
  assign rclk = {clk_a_i, clk_b_i};
  assign wreq = {b_wr, a_wr};
  assign rreq = {a_rd, b_rd};
  assign wdat[CH_AB] = a_data_i;
  assign wdat[CH_BA] = b_data_i;

  for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
    mbx_channel #(
      .DATA_W     (DATA_W),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_chan (
      .wclk_i   (wclk[ch]),
      .rclk_i   (rclk[ch]),
      .rst_ni   (rst_ni),
      .wr_req_i (wreq[ch]),
      .wdata_i  (wdat[ch]),
      .rd_req_i (rreq[ch]),
      .mail_o   (mail[ch]),
      .full_w_no(fw_n[ch]),
      .full_r_no(fr_n[ch])
    );
  end

  logic [DATA_W-1:0] ab_mail, ba_mail;
  assign ab_mail = mail[CH_AB];
  assign ba_mail = mail[CH_BA];

  assign ab_full_wr_no = fw_n[CH_AB];
  assign ab_full_rd_no = fr_n[CH_AB];
  assign ba_full_wr_no = fw_n[CH_BA];
  assign ba_full_rd_no = fr_n[CH_BA];

  // mailbox words bypass any byte steering
  assign a_data_o = a_mbx_i ? ba_mail : a_fifo_i;
  assign b_data_o = b_mbx   ? ab_mail : b_fifo_i;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned SIZE_W = 2,
  parameter logic [SIZE_W-1:0] MAIL_CODE = '1
) (
  input logic              clk_a_i,
  input logic              clk_b_i,
  input logic              rst_ni,
  input logic              a_sel_i,
  input logic              a_wr_i,
  input logic              a_en_i,
  input logic              a_mbx_i,
  input logic              b_sel_i,
  input logic              b_wr_i,
  input logic              b_en_i,
  input logic [SIZE_W-1:0] b_size_i,
  input logic              ab_full_wr_no,
  input logic              ab_full_rd_no,
  input logic [DATA_W-1:0] ab_mail_i,
  input logic [DATA_W-1:0] ba_mail_i,
  input logic [DATA_W-1:0] a_data_o
);
  a_r2_hold_unselected: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !(a_sel_i && a_wr_i && a_en_i && a_mbx_i) |=> $stable(ab_mail_i));

  a_r3_hold_unselected: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !(b_sel_i && b_wr_i && b_en_i && b_size_i == MAIL_CODE) |=> $stable(ba_mail_i));

  a_r4_flag_drops: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_sel_i && a_wr_i && a_en_i && a_mbx_i && ab_full_wr_no) |=> !ab_full_wr_no);

  a_r5_no_overwrite: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !ab_full_wr_no |=> $stable(ab_mail_i));

  a_r6_read_frees: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_sel_i && !b_wr_i && b_en_i && b_size_i == MAIL_CODE && !ab_full_rd_no)
      |=> ab_full_rd_no);

  a_r8_a_mux: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    a_mbx_i |-> a_data_o == ba_mail_i);
endmodule

bind mailbox_bridge mbx_checker #(
  .DATA_W   (DATA_W),
  .SIZE_W   (SIZE_W),
  .MAIL_CODE(MAIL_CODE)
) u_chk (
  .clk_a_i      (clk_a_i),
  .clk_b_i      (clk_b_i),
  .rst_ni       (rst_ni),
  .a_sel_i      (a_sel_i),
  .a_wr_i       (a_wr_i),
  .a_en_i       (a_en_i),
  .a_mbx_i      (a_mbx_i),
  .b_sel_i      (b_sel_i),
  .b_wr_i       (b_wr_i),
  .b_en_i       (b_en_i),
  .b_size_i     (b_size_i),
  .ab_full_wr_no(ab_full_wr_no),
  .ab_full_rd_no(ab_full_rd_no),
  .ab_mail_i    (ab_mail),
  .ba_mail_i    (ba_mail),
  .a_data_o     (a_data_o)
);

// File: tb/tb_mailbox_bridge.sv
module tb_mailbox_bridge;
  localparam int DW = 36;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic a_sel = 0, a_wr = 0, a_en = 0, a_mbx = 0;
  logic b_sel = 0, b_wr = 0, b_en = 0;
  logic [1:0] b_size = 2'b00;
  logic [DW-1:0] a_din = '0, b_din = '0, a_fifo = '0, b_fifo = '0;
  logic [DW-1:0] a_dout, b_dout;
  logic ab_w_n, ab_r_n, ba_w_n, ba_r_n;

  int nvec = 0, nerr = 0;
  logic [DW-1:0] e_ab = '0, e_ba = '0;
  bit f_ab = 0, f_ba = 0;

  always #10 clk_a = ~clk_a;
  always #17 clk_b = ~clk_b;

  mailbox_bridge dut (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .a_sel_i(a_sel), .a_wr_i(a_wr), .a_en_i(a_en), .a_mbx_i(a_mbx),
    .a_data_i(a_din), .a_fifo_i(a_fifo), .a_data_o(a_dout),
    .b_sel_i(b_sel), .b_wr_i(b_wr), .b_en_i(b_en), .b_size_i(b_size),
    .b_data_i(b_din), .b_fifo_i(b_fifo), .b_data_o(b_dout),
    .ab_full_wr_no(ab_w_n), .ab_full_rd_no(ab_r_n),
    .ba_full_wr_no(ba_w_n), .ba_full_rd_no(ba_r_n)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i) * 36'h2_4924_9249 + 36'h5_0A0A_3C3C;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h @%0t", req, got, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk_a);
    repeat (5) @(negedge clk_b);
  endtask

  task automatic check_all(input string req);
    @(negedge clk_a);
    a_mbx = 1'b1; b_size = 2'b11;
    #1;
    chk({req, " fwd mail"}, b_dout, e_ab);
    chk({req, " rev mail"}, a_dout, e_ba);
    chk({req, " ab_w flag"}, DW'(ab_w_n), DW'(!f_ab));
    chk({req, " ab_r flag"}, DW'(ab_r_n), DW'(!f_ab));
    chk({req, " ba_w flag"}, DW'(ba_w_n), DW'(!f_ba));
    chk({req, " ba_r flag"}, DW'(ba_r_n), DW'(!f_ba));
    a_mbx = 1'b0; b_size = 2'b00;
  endtask

  task automatic a_op(input logic [3:0] c, input logic [DW-1:0] d);
    @(negedge clk_a);
    {a_sel, a_wr, a_en, a_mbx} = c; a_din = d;
    @(negedge clk_a);
    {a_sel, a_wr, a_en, a_mbx} = 4'b0;
    if (c == 4'b1111 && !f_ab) begin e_ab = d; f_ab = 1; end
    if (c == 4'b1011 && f_ba) f_ba = 0;
  endtask

  task automatic b_op(input logic [4:0] c, input logic [DW-1:0] d);
    @(negedge clk_b);
    {b_sel, b_wr, b_en, b_size} = c; b_din = d;
    @(negedge clk_b);
    {b_sel, b_wr, b_en, b_size} = 5'b0;
    if (c == 5'b11111 && !f_ba) begin e_ba = d; f_ba = 1; end
    if (c == 5'b10111 && f_ab) f_ab = 0;
  endtask

  initial begin
    #4_000_000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #5;
    // R1 during reset
    chk("R1 ab_w in reset", DW'(ab_w_n), DW'(1));
    chk("R1 ba_r in reset", DW'(ba_r_n), DW'(1));
    #95 rst_n = 1'b1;
    check_all("R1");

    // R2, R6, R7, R10: every port A control combination
    for (int c = 0; c < 16; c++) begin
      a_op(4'(c), pat(c));
      settle();
      check_all("R2");
      if (f_ab) begin
        b_op(5'b10111, '0);
        settle();
        check_all("R6 R7");
      end
    end

    // R3, R6, R7, R10: every port B control combination
    for (int c = 0; c < 32; c++) begin
      b_op(5'(c), pat(c + 100));
      settle();
      check_all("R3");
      if (f_ba) begin
        a_op(4'b1011, '0);
        settle();
        check_all("R6 R7");
      end
    end

    // R4: writer flag immediate, reader flag delayed by the synchronizer
    a_op(4'b1111, pat(7001));
    chk("R4 ab_w low after edge", DW'(ab_w_n), DW'(0));
    chk("R4 ab_r not yet low", DW'(ab_r_n), DW'(1));
    settle();
    check_all("R4");
    // R6: reader flag immediate, writer flag delayed
    b_op(5'b10111, '0);
    chk("R6 ab_r high after edge", DW'(ab_r_n), DW'(1));
    chk("R6 ab_w still low", DW'(ab_w_n), DW'(0));
    settle();
    check_all("R6");

    b_op(5'b11111, pat(7002));
    chk("R4 ba_w low after edge", DW'(ba_w_n), DW'(0));
    chk("R4 ba_r not yet low", DW'(ba_r_n), DW'(1));
    settle();
    check_all("R4");

    // R5: second writes while full are dropped
    a_op(4'b1111, pat(7003));
    settle();
    a_op(4'b1111, pat(7004));
    b_op(5'b11111, pat(7005));
    settle();
    check_all("R5");

    // R10: read of an empty mailbox leaves flags alone
    b_op(5'b10111, '0);
    a_op(4'b1011, '0);
    settle();
    check_all("R10 drain");
    b_op(5'b10111, '0);
    a_op(4'b1011, '0);
    settle();
    check_all("R10 empty read");

    // R8, R9: output steering for every select value
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_a);
      a_fifo = pat(i + 300); b_fifo = pat(i + 400);
      a_mbx = i[2]; b_size = 2'(i);
      #1;
      chk("R8 a_data_o", a_dout, i[2] ? e_ba : a_fifo);
      chk("R9 b_data_o", b_dout, (i[1:0] == 2'b11) ? e_ab : b_fifo);
    end
    a_mbx = 1'b0; b_size = 2'b00;

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule